// File: doc/BRIEF.md
# Millisecond-Tick Watchdog Timer

This block is a watchdog timer controlled through four 32-bit registers on a small word-addressed register port. A fast reference clock feeds an 18-bit prescaler. The prescaler produces one tick per programmed number of reference cycles, so software can set a 1 ms tick. A 32-bit tick counter counts these ticks up to a programmed limit. When the counter reaches the limit, the block raises an expired flag. It can also drive an active-low system reset request for a fixed number of reference clocks.

Software keeps the system alive by writing anything to the kick register. To arm the timer, software clears the control register, writes the kick register, loads the limit, and then sets every enable and the prescaler count in one control write. The register port has no back-pressure: every write or read strobe is taken in the cycle it is presented. Read data is registered and appears one cycle after the strobe.

Top module: `wdg_top`

## Requirements
- R1: Word address 0 holds the control register, address 1 a free read/write scratch word, and address 2 the tick limit. A read of any of these returns the last value written to it.
- R2: A write to word address 3 clears the tick counter to zero, whatever the data. A read of address 3 returns the current tick counter value.
- R3: Control bits 17:0 hold the prescaler count P. Bit 25 enables the prescaler, and the prescaler emits one tick every max(P,1) reference cycles. The tick counter advances only while bit 25, bit 24 (count clock enable) and bit 18 (watchdog enable) are all set.
- R4: While bit 18 is clear, the tick counter and the expired flag are held at zero. Writing zero to the control register therefore stops the watchdog.
- R5: When the tick counter is at or above the limit while bit 18 is set, the expired flag rises one cycle later and the counter stops advancing. A limit of zero expires one cycle after the enabling write.
- R6: If control bit 21 is set, the expiry drives the reset request low for exactly 16 reference cycles, starting at the same edge as the expired flag. If bit 21 is clear, the reset request stays high.
- R7: A write to the kick address clears the expired flag.
- R8: A synchronous active-high reset clears all registers, the counters and the expired flag, and releases the reset request high.
- R9: Read data is captured on the clock edge that ends the read strobe cycle and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_rd | input | 1 | One-cycle read strobe |
| reg_addr | input | 2 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| sys_rst_req_n | output | 1 | Active-low system reset request |
| wdt_expired | output | 1 | Timeout reached flag |

## Verification
The bench targets these cases:
- Off-by-one errors in the prescaler period. They shift the expiry by whole tick periods, so the expiry edge is checked on the exact cycle for prescaler counts of 1 and 4.
- A limit of zero. A design that waits for a first tick before comparing misses the immediate expiry.
- A design that ignores bit 21 would pulse the reset request when it should stay high.
- A pulse that is one cycle long or short fails the checks on both ends of the 16-cycle low window.
- A design that counts with the count clock enable cleared, or does not clear on a kick, shows a nonzero count through the kick address or an unexpected expiry.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int DIV_W  = 18;
  localparam int PULSE_LEN = 16;

  localparam int BIT_DIV_EN = 25;
  localparam int BIT_CLK_EN = 24;
  localparam int BIT_RST_EN = 21;
  localparam int BIT_WD_EN  = 18;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_AUX   = 2'd1,
    REG_LIMIT = 2'd2,
    REG_KICK  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             div_en;
    logic             clk_en;
    logic             rst_en;
    logic             wd_en;
    logic [DIV_W-1:0] div_tc;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(logic [DATA_W-1:0] w);
    ctrl_t c;
    c.div_en = w[BIT_DIV_EN];
    c.clk_en = w[BIT_CLK_EN];
    c.rst_en = w[BIT_RST_EN];
    c.wd_en  = w[BIT_WD_EN];
    c.div_tc = w[DIV_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/wdg_regfile.sv
module wdg_regfile
  import wdg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] count_i,
  output logic [DW-1:0] rdata_o,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] limit_o,
  output logic          kick_o
);
  logic [DW-1:0] ctrl_q, aux_q, limit_q, rdata_q, rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      aux_q   <= '0;
      limit_q <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_CTRL:  ctrl_q  <= wdata;
        REG_AUX:   aux_q   <= wdata;
        REG_LIMIT: limit_q <= wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      REG_CTRL:  rd_mux = ctrl_q;
      REG_AUX:   rd_mux = aux_q;
      REG_LIMIT: rd_mux = limit_q;
      default:   rd_mux = count_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign kick_o  = wr_en && (addr == REG_KICK);
  assign ctrl_o  = unpack_ctrl(ctrl_q);
  assign limit_o = limit_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] tc,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   cnt_inc;
  logic         wrap;

  assign cnt_inc = {1'b0, cnt_q} + (W+1)'(1);
  assign wrap    = cnt_inc >= {1'b0, tc};

  always_ff @(posedge clk) begin
    if (rst || !en) cnt_q <= '0;
    else if (wrap)  cnt_q <= '0;
    else            cnt_q <= cnt_inc[W-1:0];
  end

  assign tick_o = en && wrap;
endmodule

// File: rtl/wdg_tick_ctr.sv
module wdg_tick_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wd_en,
  input  logic         run,
  input  logic         tick,
  input  logic         kick,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count_o,
  output logic         expired_o,
  output logic         expire_evt_o
);
  logic [W-1:0] count_q;
  logic         expired_q, at_limit, evt;

  assign at_limit = count_q >= limit;
  assign evt      = wd_en && at_limit && !expired_q && !kick;

  always_ff @(posedge clk) begin
    if (rst || !wd_en) begin
      count_q   <= '0;
      expired_q <= 1'b0;
    end else if (kick) begin
      count_q   <= '0;
      expired_q <= 1'b0;
    end else begin
      if (evt) expired_q <= 1'b1;
      if (run && tick && !at_limit) count_q <= count_q + W'(1);
    end
  end

  assign count_o      = count_q;
  assign expired_o    = expired_q;
  assign expire_evt_o = evt;
endmodule

// File: rtl/wdg_pulse_gen.sv
module wdg_pulse_gen #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic rst_n_o
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (rst)                pcnt_q <= '0;
    else if (start)         pcnt_q <= CW'(LEN);
    else if (pcnt_q != '0)  pcnt_q <= pcnt_q - CW'(1);
  end

  assign rst_n_o = (pcnt_q == '0);
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sys_rst_req_n,
  output logic              wdt_expired
);
  ctrl_t             ctrl_s;
  logic [DATA_W-1:0] limit_q, tick_count;
  logic              kick, tick, run, expire_evt;

  wdg_regfile #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .count_i(tick_count), .rdata_o(reg_rdata),
    .ctrl_o(ctrl_s), .limit_o(limit_q), .kick_o(kick)
  );

  wdg_prescaler #(.W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .en(ctrl_s.div_en), .tc(ctrl_s.div_tc), .tick_o(tick)
  );

  assign run = ctrl_s.wd_en && ctrl_s.clk_en && ctrl_s.div_en;

  wdg_tick_ctr #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .wd_en(ctrl_s.wd_en), .run(run), .tick(tick),
    .kick(kick), .limit(limit_q), .count_o(tick_count),
    .expired_o(wdt_expired), .expire_evt_o(expire_evt)
  );

  wdg_pulse_gen #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .start(expire_evt && ctrl_s.rst_en), .rst_n_o(sys_rst_req_n)
  );
endmodule

// File: rtl/wdg_top_chk.sv
module wdg_top_chk #(
  parameter int DW  = 32,
  parameter int LEN = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic          sys_rst_req_n,
  input logic          wdt_expired,
  input logic [DW-1:0] tick_count,
  input logic [DW-1:0] limit_q,
  input logic          wd_en,
  input logic          rst_en
);
  logic [5:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)                 low_run <= '0;
    else if (!sys_rst_req_n) low_run <= (low_run == 6'd63) ? low_run : low_run + 6'd1;
    else                     low_run <= '0;
  end

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd3) |=> (tick_count == '0 && !wdt_expired)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (tick_count != $past(tick_count)) |-> (tick_count == '0 || tick_count == $past(tick_count) + DW'(1))); // R3
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !wd_en |=> (tick_count == '0 && !wdt_expired)); // R4
  AST_EXPIRE_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_expired) |-> $past(tick_count >= limit_q)); // R5
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_req_n) |-> $past(rst_en)); // R6
  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (rst)
    low_run <= 6'(LEN)); // R6
  AST_RESET_RELEASES: assert property (@(posedge clk)
    rst |=> (sys_rst_req_n && !wdt_expired)); // R8
endmodule

bind wdg_top wdg_top_chk #(.DW(32), .LEN(16)) i_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .sys_rst_req_n(sys_rst_req_n), .wdt_expired(wdt_expired),
  .tick_count(tick_count), .limit_q(limit_q),
  .wd_en(ctrl_s.wd_en), .rst_en(ctrl_s.rst_en)
);

// File: tb/test_wdg_top.sv
`timescale 1ns/1ps
module test_wdg_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sys_rst_req_n, wdt_expired;
  int checks = 0, failures = 0;
  bit done = 0;

  localparam logic [31:0] DIV_EN = 32'h0200_0000;
  localparam logic [31:0] CLK_EN = 32'h0100_0000;
  localparam logic [31:0] RST_EN = 32'h0020_0000;
  localparam logic [31:0] WD_EN  = 32'h0004_0000;

  typedef struct packed {
    logic [1:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{2'd1, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    '{2'd2, 32'h0000_3E80, 32'h0000_3E80},
    '{2'd0, 32'h0003_FFFF, 32'h0003_FFFF},
    '{2'd0, 32'h0020_5DC0, 32'h0020_5DC0},
    '{2'd3, 32'hDEAD_BEEF, 32'h0000_0000},
    '{2'd1, 32'h0000_0000, 32'h0000_0000},
    '{2'd0, 32'h0000_0000, 32'h0000_0000}
  };

  always #2.5 clk = ~clk;

  wdg_top i_wdg_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sys_rst_req_n(sys_rst_req_n), .wdt_expired(wdt_expired)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic arm(input logic [31:0] limit, input logic [31:0] ctrl);
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h0);
    wr(2'd2, limit);
    wr(2'd0, ctrl);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    @(negedge clk); step(2);
    check("R8 reset rst_n", {31'b0, sys_rst_req_n}, 32'd1);
    check("R8 reset expired", {31'b0, wdt_expired}, 32'd0);
    rst = 1'b0;
    rd(2'd0, v); check("R8 ctrl after reset", v, 32'h0);
    rd(2'd2, v); check("R8 limit after reset", v, 32'h0);

    for (int i = 0; i < 7; i++) begin
      wr(VECS[i].a, VECS[i].d);
      rd(VECS[i].a, v);
      check("R1/R2 table readback", v, VECS[i].exp);
    end

    // R9: rdata holds with no read strobe
    wr(2'd1, 32'h1234_5678);
    step(2);
    check("R9 rdata held", reg_rdata, 32'h0);

    // R5/R6: prescaler 4, limit 3, reset output on
    arm(32'd3, DIV_EN | CLK_EN | RST_EN | WD_EN | 32'd4);
    step(12);
    check("R5 not yet expired", {31'b0, wdt_expired}, 32'd0);
    check("R6 not yet low", {31'b0, sys_rst_req_n}, 32'd1);
    step(1);
    check("R5 expired edge", {31'b0, wdt_expired}, 32'd1);
    check("R6 pulse start", {31'b0, sys_rst_req_n}, 32'd0);
    step(15);
    check("R6 pulse last low", {31'b0, sys_rst_req_n}, 32'd0);
    step(1);
    check("R6 pulse ended", {31'b0, sys_rst_req_n}, 32'd1);
    rd(2'd3, v); check("R5 count held at limit", v, 32'd3);
    wr(2'd3, 32'hFFFF_FFFF);
    check("R7 kick clears expired", {31'b0, wdt_expired}, 32'd0);

    // R5: limit zero expires at once
    arm(32'd0, DIV_EN | CLK_EN | RST_EN | WD_EN | 32'd4);
    check("R5 limit0 not before", {31'b0, wdt_expired}, 32'd0);
    step(1);
    check("R5 limit0 expired", {31'b0, wdt_expired}, 32'd1);
    check("R6 limit0 pulse", {31'b0, sys_rst_req_n}, 32'd0);
    step(20);

    // R3/R6: prescaler 1, limit 2, reset output off
    arm(32'd2, DIV_EN | CLK_EN | WD_EN | 32'd1);
    step(2);
    check("R3 div1 not yet", {31'b0, wdt_expired}, 32'd0);
    step(1);
    check("R3 div1 expired", {31'b0, wdt_expired}, 32'd1);
    check("R6 no pulse without enable", {31'b0, sys_rst_req_n}, 32'd1);
    step(5);
    check("R6 still high", {31'b0, sys_rst_req_n}, 32'd1);

    // R2/R3: count readback with prescaler 2
    arm(32'd100, DIV_EN | CLK_EN | WD_EN | 32'd2);
    step(9);
    rd(2'd3, v); check("R2 count readback", v, 32'd4);

    // R2: periodic kicks prevent expiry
    arm(32'd3, DIV_EN | CLK_EN | RST_EN | WD_EN | 32'd2);
    for (int k = 0; k < 10; k++) begin
      step(3);
      wr(2'd3, 32'(k));
    end
    check("R2 kicks hold off expiry", {31'b0, wdt_expired}, 32'd0);
    check("R2 kicks no pulse", {31'b0, sys_rst_req_n}, 32'd1);

    // R4: clearing control stops and clears
    step(10);
    wr(2'd0, 32'h0);
    step(1);
    rd(2'd3, v); check("R4 count cleared", v, 32'd0);
    check("R4 expired cleared", {31'b0, wdt_expired}, 32'd0);

    // R3: clock enable off, no counting
    wr(2'd3, 32'h0);
    wr(2'd0, DIV_EN | WD_EN | 32'd1);
    step(10);
    rd(2'd3, v); check("R3 no count without clk enable", v, 32'd0);
    check("R3 no expiry without clk enable", {31'b0, wdt_expired}, 32'd0);

    // R8: reset in the middle of a run
    arm(32'd5, DIV_EN | CLK_EN | WD_EN | 32'd1);
    step(3);
    rst = 1'b1; step(2); rst = 1'b0;
    rd(2'd0, v); check("R8 ctrl cleared mid-run", v, 32'h0);
    rd(2'd3, v); check("R8 count cleared mid-run", v, 32'h0);
    check("R8 rst_n high", {31'b0, sys_rst_req_n}, 32'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule